// File: doc/BRIEF.md
# Flash Rewrite Control Register Unit

This block holds the two byte-wide control registers through which software steers self-rewriting of an on-chip flash array. A first register carries the rewrite-mode enable, a lock-protection bypass, a reset for the flash sequencer, a user/boot area selector and a read-only view of the sequencer's ready flag. A second register carries a flash power-off control. The rewrite-mode enable, the bypass and the power-off control are protected: each is set only by a write of 0 to that bit followed, on the very next write to the same register, by a write of 1.

Besides the registers, the block sits on the command path from the CPU to the flash sequencer. It forwards a command word only if all of these hold: the address is even, rewrite mode is on, the sequencer is out of reset and the flash is powered. Every other command is accepted and dropped. Flash power is removed whenever the CPU is in stop or wait, whatever the power-off bit holds.

The command path is valid/ready. A forwarded command is passed straight through: `seq_valid` follows `cmd_valid`, and `cmd_ready` follows `seq_ready`, so the sequencer's back-pressure reaches the CPU side unchanged. A dropped command sees `cmd_ready` high and produces no `seq_valid`. The sender must hold `cmd_addr` and `cmd_data` stable while `cmd_valid` is high and `cmd_ready` is low.

Top module: `flash_rewrite_ctrl`

## Requirements
- R1: After reset every stored control bit is 0. With `flash_ready`=1, register 0 reads 0x01 and register 1 reads 0x00. Outside boot mode `user_area`=1 and `flash_pwr_en`=1.
- R2: Rewrite mode (register 0, bit 1) becomes 1 when a write with bit 1 = 1 directly follows a write to register 0 with bit 1 = 0. Any write to register 0 with bit 1 = 0 clears it.
- R3: A write of 1 to a protected bit that is not directly preceded by a write of 0 to that bit in the same register leaves the bit unchanged. This applies to the first write after reset and to a second write of 1. Writes to the other register neither arm nor cancel.
- R4: Lock bypass (register 0, bit 2) uses the same arming and takes writes only while rewrite mode is 1. It is cleared in the same cycle that rewrite mode is cleared. While it is 1, `erase_unlock` is 1, so an erase changes locked lock bits to unlocked.
- R5: Sequencer reset (register 0, bit 3) is set by writing 1 while rewrite mode is 1 and is ignored otherwise. It stays set until a write of 0 to bit 3.
- R6: Register 0, bit 5 is a plain read/write bit. In boot mode `user_area` equals that bit, whatever the rewrite-mode state. Outside boot mode `user_area` is 1.
- R7: Power-off (register 1, bit 3) uses the 0-then-1 arming. While it is 1, `flash_pwr_en` is 0 and no command is forwarded.
- R8: While `cpu_stop` or `cpu_wait` is 1, `flash_pwr_en` is 0. It returns to 1 when both inputs fall, provided the power-off bit is 0. The stored power-off bit is not changed by this.
- R9: A command with an even `cmd_addr` (bit 0 = 0) is forwarded when rewrite mode is 1, the sequencer reset is 0 and the flash is powered, with `seq_addr`/`seq_data` equal to the inputs and `cmd_ready` = `seq_ready`. Any other command gives `seq_valid`=0 and `cmd_ready`=1.
- R10: Register 0, bit 0 reads `flash_ready` and cannot be written. Bits 4, 6 and 7 of register 0, and all bits of register 1 other than bit 3, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_sel | input | 1 | Register select: 0 = control register 0, 1 = control register 1 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| flash_ready | input | 1 | Sequencer ready flag, 0 while a program or erase runs |
| boot_mode | input | 1 | Device booted in boot mode |
| cpu_stop | input | 1 | CPU is in stop |
| cpu_wait | input | 1 | CPU is in wait |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted (forwarded or dropped) |
| cmd_addr | input | ADDR_W | Command byte address |
| cmd_data | input | DATA_W | Command or data word |
| seq_valid | output | 1 | Forwarded command valid to the sequencer |
| seq_ready | input | 1 | Sequencer can take a command |
| seq_addr | output | ADDR_W | Forwarded address |
| seq_data | output | DATA_W | Forwarded word |
| rw_mode | output | 1 | Rewrite mode enable |
| lock_bypass | output | 1 | Lock protection bypassed |
| erase_unlock | output | 1 | An erase must also unlock the locked lock bits |
| seq_reset | output | 1 | Reset to the flash sequencer |
| user_area | output | 1 | 1 = user area is mapped, 0 = boot area |
| flash_pwr_en | output | 1 | Flash supply enabled |

## Verification
The bench aims at the arming rules. It writes a 1 with no prior 0 and expects no effect, which catches a design that treats a protected bit as plain. It puts a write to the other register between the 0 and the 1, which catches a design that shares one arming flag across registers. It clears rewrite mode while bypass is set and expects bypass to drop in the same write, which exposes a design that clears it late or not at all. Odd command addresses, back-pressure, and commands sent while the sequencer is in reset or while power is cut by stop or wait are each driven, so that a filter that leaks a command or drops the ready path shows up at the ports.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned REG_W = 8;
  // control register 0 fields
  localparam int unsigned C0_READY = 0;
  localparam int unsigned C0_RW    = 1;
  localparam int unsigned C0_BYP   = 2;
  localparam int unsigned C0_SRST  = 3;
  localparam int unsigned C0_UAREA = 5;
  // control register 1 fields
  localparam int unsigned C1_PWROFF = 3;
  // protected (armed) bits
  localparam int unsigned NUM_ARM = 3;
  localparam int unsigned ARM_RW  = 0;
  localparam int unsigned ARM_BYP = 1;
  localparam int unsigned ARM_PWR = 2;

  typedef enum logic {
    SEL_CTRL0 = 1'b0,
    SEL_CTRL1 = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frc_arm_bit.sv
module frc_arm_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  input  logic allow,
  input  logic force_clr,
  output logic q
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= 1'b0;
      armed_q <= 1'b0;
    end else if (force_clr) begin
      q       <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr && allow) begin
      if (!wbit) begin
        q       <= 1'b0;
        armed_q <= 1'b1;
      end else begin
        if (armed_q) q <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  // R2 / R3: a protected bit can only rise on an armed write of 1
  a_r3_set_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(armed_q && wr && wbit && allow));

  // R2: a permitted write of 0 always leaves the bit cleared
  a_r2_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && allow && !wbit) |=> !q);
endmodule

// File: rtl/frc_power.sv
module frc_power (
  input  logic pwr_off,
  input  logic cpu_stop,
  input  logic cpu_wait,
  output logic pwr_en
);
  logic cpu_halted;

  always_comb begin
    cpu_halted = cpu_stop | cpu_wait;
    pwr_en     = !(pwr_off || cpu_halted);
  end
endmodule

// File: rtl/frc_cmd_filter.sv
module frc_cmd_filter #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_en,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              seq_valid,
  input  logic              seq_ready,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_data
);
  logic even_addr;
  logic forward;

  always_comb begin
    even_addr = !cmd_addr[0];
    forward   = pass_en && even_addr;
    seq_valid = cmd_valid && forward;
    cmd_ready = forward ? seq_ready : 1'b1;
    seq_addr  = cmd_addr;
    seq_data  = cmd_data;
  end

  // R9: odd addresses never reach the sequencer
  a_r9_odd_never_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid |-> !seq_addr[0]);

  // R9: a dropped command is always accepted
  a_r9_drop_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !seq_valid) |-> cmd_ready);
endmodule

// File: rtl/flash_rewrite_ctrl.sv
module flash_rewrite_ctrl
  import frc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              flash_ready,
  input  logic              boot_mode,
  input  logic              cpu_stop,
  input  logic              cpu_wait,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              seq_valid,
  input  logic              seq_ready,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_data,
  output logic              rw_mode,
  output logic              lock_bypass,
  output logic              erase_unlock,
  output logic              seq_reset,
  output logic              user_area,
  output logic              flash_pwr_en
);
  logic wr0, wr1;
  logic [NUM_ARM-1:0] arm_wr, arm_wbit, arm_allow, arm_clr, arm_q;
  logic srst_q, uarea_q;
  logic pass_en;
  logic unused_wbits;

  always_comb begin
    wr0 = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL0);
    wr1 = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL1);

    arm_wr[ARM_RW]    = wr0;
    arm_wbit[ARM_RW]  = reg_wdata[C0_RW];
    arm_allow[ARM_RW] = 1'b1;
    arm_clr[ARM_RW]   = 1'b0;

    arm_wr[ARM_BYP]    = wr0;
    arm_wbit[ARM_BYP]  = reg_wdata[C0_BYP];
    arm_allow[ARM_BYP] = arm_q[ARM_RW];
    arm_clr[ARM_BYP]   = !arm_q[ARM_RW] || (wr0 && !reg_wdata[C0_RW]);

    arm_wr[ARM_PWR]    = wr1;
    arm_wbit[ARM_PWR]  = reg_wdata[C1_PWROFF];
    arm_allow[ARM_PWR] = 1'b1;
    arm_clr[ARM_PWR]   = 1'b0;
  end

  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[4], reg_wdata[0]};

  for (genvar i = 0; i < NUM_ARM; i++) begin : g_arm
    frc_arm_bit u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (arm_wr[i]),
      .wbit      (arm_wbit[i]),
      .allow     (arm_allow[i]),
      .force_clr (arm_clr[i]),
      .q         (arm_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      uarea_q <= 1'b0;
    end else if (wr0) begin
      uarea_q <= reg_wdata[C0_UAREA];
      if (!reg_wdata[C0_SRST])  srst_q <= 1'b0;
      else if (arm_q[ARM_RW])   srst_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel_e'(reg_sel) == SEL_CTRL0) begin
      reg_rdata[C0_READY] = flash_ready;
      reg_rdata[C0_RW]    = arm_q[ARM_RW];
      reg_rdata[C0_BYP]   = arm_q[ARM_BYP];
      reg_rdata[C0_SRST]  = srst_q;
      reg_rdata[C0_UAREA] = uarea_q;
    end else begin
      reg_rdata[C1_PWROFF] = arm_q[ARM_PWR];
    end
  end

  frc_power u_power (
    .pwr_off  (arm_q[ARM_PWR]),
    .cpu_stop (cpu_stop),
    .cpu_wait (cpu_wait),
    .pwr_en   (flash_pwr_en)
  );

  assign pass_en = arm_q[ARM_RW] && !srst_q && flash_pwr_en;

  frc_cmd_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_en   (pass_en),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .seq_valid (seq_valid),
    .seq_ready (seq_ready),
    .seq_addr  (seq_addr),
    .seq_data  (seq_data)
  );

  assign rw_mode      = arm_q[ARM_RW];
  assign lock_bypass  = arm_q[ARM_BYP];
  assign erase_unlock = arm_q[ARM_BYP];
  assign seq_reset    = srst_q;
  assign user_area    = boot_mode ? uarea_q : 1'b1;

  // R4: bypass never outlives rewrite mode
  a_r4_bypass_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bypass |-> rw_mode);

  // R5: the sequencer reset only rises while rewrite mode was on
  a_r5_srst_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_reset) |-> $past(rw_mode));

  // R5: the sequencer reset only falls on a write of 0 to its bit
  a_r5_srst_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_reset) |-> $past(wr0 && !reg_wdata[C0_SRST]));

  // R8: stop or wait always removes flash power
  a_r8_halt_cuts_power: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stop || cpu_wait) |-> !flash_pwr_en);

  // R7: nothing reaches an unpowered flash
  a_r7_no_access_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_pwr_en |-> !seq_valid);
endmodule

// File: tb/flash_rewrite_ctrl_tb.sv
module flash_rewrite_ctrl_tb_top;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_sel = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              flash_ready = 1'b1;
  logic              boot_mode = 1'b0;
  logic              cpu_stop = 1'b0;
  logic              cpu_wait = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic              seq_valid;
  logic              seq_ready = 1'b1;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_data;
  logic              rw_mode, lock_bypass, erase_unlock, seq_reset, user_area, flash_pwr_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_rewrite_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_ready(flash_ready),
    .boot_mode(boot_mode), .cpu_stop(cpu_stop), .cpu_wait(cpu_wait),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .seq_valid(seq_valid), .seq_ready(seq_ready),
    .seq_addr(seq_addr), .seq_data(seq_data), .rw_mode(rw_mode),
    .lock_bypass(lock_bypass), .erase_unlock(erase_unlock),
    .seq_reset(seq_reset), .user_area(user_area), .flash_pwr_en(flash_pwr_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one register write, inputs changed at the falling edge
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); check("R1 ctrl0 after reset", v, 8'h01);
    rd(1'b1, v); check("R1 ctrl1 after reset", v, 8'h00);
    check("R1 outputs after reset",
          {rw_mode, lock_bypass, erase_unlock, seq_reset, user_area, flash_pwr_en}, 6'b000011);
    wr(1'b1, 8'h08);
    rd(1'b1, v); check("R3 power-off write 1 unarmed", v, 8'h00);
    wr(1'b0, 8'h02);
    check("R3 rewrite write 1 unarmed", rw_mode, 1'b0);
  endtask

  task automatic t_rw_arm();
    logic [7:0] v;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);  // other register, does not cancel
    wr(1'b0, 8'h02);
    check("R2 rewrite set after 0 then 1", rw_mode, 1'b1);
    check("R3 other-register write kept arming", rw_mode, 1'b1);
    rd(1'b0, v); check("R2 ctrl0 read with rewrite", v, 8'h03);
    wr(1'b0, 8'h02);
    check("R3 second write 1 keeps bit", rw_mode, 1'b1);
    wr(1'b0, 8'h00);
    check("R2 single write 0 clears", rw_mode, 1'b0);
  endtask

  task automatic t_bypass();
    logic [7:0] v;
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h04);  // rewrite off: bypass ignored, bit1=0 arms rewrite
    check("R4 bypass ignored without rewrite", lock_bypass, 1'b0);
    wr(1'b0, 8'h02);
    check("R4 rewrite on", rw_mode, 1'b1);
    wr(1'b0, 8'h02);  // arm bypass
    wr(1'b0, 8'h06);
    check("R4 bypass set", lock_bypass, 1'b1);
    check("R4 erase unlock follows bypass", erase_unlock, 1'b1);
    rd(1'b0, v); check("R4 ctrl0 read with bypass", v, 8'h07);
    wr(1'b0, 8'h04);  // clears rewrite
    check("R4 bypass cleared with rewrite", {rw_mode, lock_bypass, erase_unlock}, 3'b000);
  endtask

  task automatic t_seq_reset();
    logic [7:0] v;
    wr(1'b0, 8'h08);
    check("R5 reset ignored without rewrite", seq_reset, 1'b0);
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h0A);
    check("R5 reset set in rewrite", seq_reset, 1'b1);
    rd(1'b0, v); check("R5 ctrl0 read with reset", v, 8'h0B);
    @(negedge clk); @(negedge clk);
    check("R5 reset held", seq_reset, 1'b1);
    wr(1'b0, 8'h02);
    check("R5 reset released by write 0", seq_reset, 1'b0);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_user_area();
    boot_mode = 1'b1; #1;
    check("R6 boot area selected", user_area, 1'b0);
    wr(1'b0, 8'h20);
    check("R6 user area in boot, rewrite off", {user_area, rw_mode}, 2'b10);
    boot_mode = 1'b0; wr(1'b0, 8'h00);
    check("R6 user area outside boot", user_area, 1'b1);
    boot_mode = 1'b1; #1;
    check("R6 boot follows bit 0", user_area, 1'b0);
    boot_mode = 1'b0; #1;
  endtask

  task automatic t_power();
    logic [7:0] v;
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h08);
    rd(1'b1, v); check("R7 power-off set", v, 8'h08);
    check("R7 flash power cut", flash_pwr_en, 1'b0);
    wr(1'b1, 8'h00);
    check("R7 flash power back", flash_pwr_en, 1'b1);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    cpu_stop = 1'b1; #1;
    check("R8 stop cuts power", flash_pwr_en, 1'b0);
    cpu_stop = 1'b0; cpu_wait = 1'b1; #1;
    check("R8 wait cuts power", flash_pwr_en, 1'b0);
    rd(1'b1, v); check("R8 power-off bit untouched", v, 8'h00);
    cpu_wait = 1'b0; #1;
    check("R8 power restored", flash_pwr_en, 1'b1);
  endtask

  task automatic t_cmd();
    wr(1'b0, 8'h00); wr(1'b0, 8'h02);
    cmd_valid = 1'b1; cmd_addr = 20'h0_1234; cmd_data = 16'h40A5; seq_ready = 1'b1; #1;
    check("R9 even command forwarded", {seq_valid, cmd_ready}, 2'b11);
    check("R9 forwarded address", seq_addr, 20'h0_1234);
    check("R9 forwarded data", seq_data, 16'h40A5);
    seq_ready = 1'b0; #1;
    check("R9 back-pressure", {seq_valid, cmd_ready}, 2'b10);
    cmd_addr = 20'h0_1235; #1;
    check("R9 odd command dropped", {seq_valid, cmd_ready}, 2'b01);
    cmd_addr = 20'h0_1234; cpu_wait = 1'b1; #1;
    check("R7 no command while unpowered", {seq_valid, cmd_ready}, 2'b01);
    cpu_wait = 1'b0; cmd_valid = 1'b0;
    wr(1'b0, 8'h0A);
    cmd_valid = 1'b1; seq_ready = 1'b1; #1;
    check("R9 no command in sequencer reset", {seq_valid, cmd_ready}, 2'b01);
    cmd_valid = 1'b0;
    wr(1'b0, 8'h00);
    cmd_valid = 1'b1; #1;
    check("R9 no command without rewrite", {seq_valid, cmd_ready}, 2'b01);
    cmd_valid = 1'b0;
  endtask

  task automatic t_unused();
    logic [7:0] v;
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R10 ctrl1 unused bits", v, 8'h08);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check("R10 ctrl0 unused bits", v & 8'hD0, 8'h00);
    flash_ready = 1'b0;
    wr(1'b0, 8'h01);
    rd(1'b0, v); check("R10 ready flag read-only", v[0], 1'b0);
    flash_ready = 1'b1; #1;
    rd(1'b0, v); check("R10 ready flag follows input", v[0], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw_arm();
    t_bypass();
    t_seq_reset();
    t_user_area();
    t_power();
    t_halt();
    t_cmd();
    t_unused();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule